// File: doc/BRIEF.md
# Associative Dynamic Barrier Matcher

This block holds a small set of pending barriers for a group of processors and completes them in the order in which they are satisfied at run time. Each pending barrier is a participation mask with one bit per processor. A processor raises its bit of the wait vector when it reaches a barrier. It holds that bit until the matcher pulses its release bit.

Every stored barrier is compared in parallel against the vector of waiting processors. A barrier whose participants are all waiting completes, even if older barriers are still pending, as long as no older pending barrier shares a processor with it. This keeps the order between barriers that touch the same processor. Barriers on disjoint processor sets complete independently, and several can complete in the same cycle. A completed barrier frees its slot at once. New masks may enter any free slot and are refused while every slot is occupied.

Top module: `barrier_matcher`

## Requirements
- R1: While reset is held and on the first cycle after it, `releaseVec` is all zeros and `insReady` is 1.
- R2: `insReady` is 0 exactly when all four slots hold a barrier. A mask offered with `insValid` high while `insReady` is 0 is not stored, and its processors are never released by it.
- R3: An offered mask that is all zeros is not stored and occupies no slot.
- R4: When every participant of an eligible stored barrier is waiting in cycle N, `releaseVec` equals that barrier's mask in cycle N+1 only, and the barrier's slot is free from cycle N+1.
- R5: A barrier for which only some of its participants are waiting produces no release bit.
- R6: A younger barrier whose processors share no bit with any older pending barrier completes as soon as it is satisfied, before older unsatisfied barriers.
- R7: A barrier stays pending while any older pending barrier shares a processor with it, even if all its own participants are waiting. It becomes eligible in the cycle after that older barrier completes. A barrier inserted in the same cycle that an overlapping barrier completes is not ordered behind it.
- R8: Several eligible barriers on disjoint processor sets that are satisfied in the same cycle all complete together, and `releaseVec` is the union of their masks.
- R9: A processor whose release bit is 1 in a cycle is treated as not waiting in that cycle.
- R10: A processor that is waiting but is not covered by any completing barrier gets no release bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| waitVec | input | NumProcs | Bit p is 1 while processor p is halted at a barrier |
| insValid | input | 1 | Offers `insMask` for insertion this cycle |
| insMask | input | NumProcs | Participation mask of the offered barrier, bit p for processor p |
| insReady | output | 1 | 1 while at least one slot is free |
| releaseVec | output | NumProcs | One-cycle pulse per released processor |

## Verification
Two functions can fall in the same cycle, and both are forced on purpose. First, disjoint barriers are satisfied in a single cycle: their release must be the exact union, and a waiting processor outside them must stay halted. Second, a new mask is inserted in the very cycle an overlapping older barrier completes, and the bench checks that the newcomer completes on its own later wait, without being blocked. A scoreboard queue holds the expected release vector and ready flag for each cycle, and a monitor compares them against the outputs after every edge.

// File: rtl/barrier_matcher_pkg.sv
package barrier_matcher_pkg;

  // Number of barrier slots; half the default processor count.
  localparam int unsigned SLOT_COUNT = 4;

  typedef logic [SLOT_COUNT-1:0] slotVecT;

  // Strobes sent from control to datapath each cycle.
  typedef struct packed {
    slotVecT load;  // one-hot: slot that captures insMask
    slotVecT fire;  // slots that complete this cycle
  } strobeT;

endpackage

// File: rtl/bm_datapath.sv
module bm_datapath
  import barrier_matcher_pkg::*;
#(
  parameter int unsigned NumProcs = 8
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NumProcs-1:0]                  waitVec,
  input  logic [NumProcs-1:0]                  insMask,
  input  strobeT                               strobes,
  output slotVecT                              covered,
  output logic [SLOT_COUNT-1:0][SLOT_COUNT-1:0] overlap,
  output logic                                 insNonZero,
  output logic [NumProcs-1:0]                  releaseVec
);

  typedef logic [NumProcs-1:0] procVecT;

  procVecT maskReg [SLOT_COUNT];
  procVecT effWait;
  procVecT releaseNext;

  // Processors being released this cycle do not count as waiting.
  assign effWait    = waitVec & ~releaseVec;
  assign insNonZero = |insMask;

  for (genvar i = 0; i < SLOT_COUNT; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskReg[i] <= '0;
      end else if (strobes.load[i]) begin
        maskReg[i] <= insMask;
      end
    end

    // Subset test: all participants of slot i are waiting.
    assign covered[i] = ((effWait & maskReg[i]) == maskReg[i]);

    for (genvar j = 0; j < SLOT_COUNT; j++) begin : g_pair
      assign overlap[i][j] = |(maskReg[i] & maskReg[j]);
    end
  end

  always_comb begin
    releaseNext = '0;
    for (int i = 0; i < SLOT_COUNT; i++) begin
      if (strobes.fire[i]) releaseNext = releaseNext | maskReg[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      releaseVec <= '0;
    end else begin
      releaseVec <= releaseNext;
    end
  end

endmodule

// File: rtl/bm_control.sv
module bm_control
  import barrier_matcher_pkg::*;
(
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 insValid,
  input  logic                                 insNonZero,
  input  slotVecT                              covered,
  input  logic [SLOT_COUNT-1:0][SLOT_COUNT-1:0] overlap,
  output logic                                 insReady,
  output strobeT                               strobes,
  output slotVecT                              validVec
);

  slotVecT validReg;
  slotVecT blocked;
  slotVecT freeOneHot;
  slotVecT survivors;
  // olderThan[i][j] = 1 when slot j holds a barrier older than slot i.
  logic [SLOT_COUNT-1:0][SLOT_COUNT-1:0] olderThan;

  assign validVec = validReg;
  assign insReady = ~&validReg;

  // Lowest free slot takes the next insertion.
  always_comb begin
    freeOneHot = '0;
    for (int i = 0; i < SLOT_COUNT; i++) begin
      if (!validReg[i] && (freeOneHot == '0)) freeOneHot[i] = 1'b1;
    end
  end

  for (genvar i = 0; i < SLOT_COUNT; i++) begin : g_elig
    assign blocked[i] = |(olderThan[i] & validReg & overlap[i]);
  end

  assign strobes.fire = validReg & ~blocked & covered;
  assign strobes.load = (insValid && insReady && insNonZero) ? freeOneHot : '0;
  assign survivors    = validReg & ~strobes.fire;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validReg <= '0;
    end else begin
      validReg <= survivors | strobes.load;
    end
  end

  for (genvar i = 0; i < SLOT_COUNT; i++) begin : g_age
    always_ff @(posedge clk) begin
      if (!rstN) begin
        olderThan[i] <= '0;
      end else if (strobes.load[i]) begin
        // Everything still pending after this cycle is older.
        olderThan[i] <= survivors;
      end else begin
        // A refilled slot is younger than every other entry.
        olderThan[i] <= olderThan[i] & ~strobes.load;
      end
    end
  end

endmodule

// File: rtl/barrier_matcher.sv
module barrier_matcher
  import barrier_matcher_pkg::*;
#(
  parameter int unsigned NumProcs = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NumProcs-1:0] waitVec,
  input  logic                insValid,
  input  logic [NumProcs-1:0] insMask,
  output logic                insReady,
  output logic [NumProcs-1:0] releaseVec
);

  strobeT                               strobes;
  slotVecT                              covered;
  slotVecT                              validVec;
  logic [SLOT_COUNT-1:0][SLOT_COUNT-1:0] overlap;
  logic                                 insNonZero;

  bm_control i_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .insValid   (insValid),
    .insNonZero (insNonZero),
    .covered    (covered),
    .overlap    (overlap),
    .insReady   (insReady),
    .strobes    (strobes),
    .validVec   (validVec)
  );

  bm_datapath #(.NumProcs(NumProcs)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .waitVec    (waitVec),
    .insMask    (insMask),
    .strobes    (strobes),
    .covered    (covered),
    .overlap    (overlap),
    .insNonZero (insNonZero),
    .releaseVec (releaseVec)
  );

endmodule

// File: rtl/bm_checker.sv
module bm_checker
  import barrier_matcher_pkg::*;
#(
  parameter int unsigned NumProcs = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [NumProcs-1:0] waitVec,
  input logic                insReady,
  input logic [NumProcs-1:0] releaseVec,
  input strobeT              strobes,
  input slotVecT             validVec
);

  AST_REL_WAS_WAITING: assert property (@(posedge clk) disable iff (!rstN)
    (releaseVec & ~$past(waitVec)) == '0);  // R10

  AST_REL_NOT_TWICE: assert property (@(posedge clk) disable iff (!rstN)
    (releaseVec & $past(releaseVec)) == '0);  // R9

  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.load));  // R2

  AST_FULL_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !insReady |-> (strobes.load == '0));  // R2

  AST_FIRE_ONLY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.fire & ~validVec) == '0);  // R4

  AST_FIRE_FREES: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.fire != '0) |=> (validVec & $past(strobes.fire)) == '0);  // R4

endmodule

bind barrier_matcher bm_checker #(.NumProcs(NumProcs)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .waitVec    (waitVec),
  .insReady   (insReady),
  .releaseVec (releaseVec),
  .strobes    (strobes),
  .validVec   (validVec)
);

// File: tb/test_barrier_matcher.sv
module test_barrier_matcher;

  localparam int unsigned P = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [P-1:0] waitVec = '0;
  logic         insValid = 1'b0;
  logic [P-1:0] insMask = '0;
  logic         insReady;
  logic [P-1:0] releaseVec;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [P-1:0] rel;
    logic         rdy;
    string        tag;
  } expT;

  expT expQ[$];

  always #4 clk = ~clk;  // 125 MHz

  barrier_matcher #(.NumProcs(P)) i_barrier_matcher (
    .clk        (clk),
    .rstN       (rstN),
    .waitVec    (waitVec),
    .insValid   (insValid),
    .insMask    (insMask),
    .insReady   (insReady),
    .releaseVec (releaseVec)
  );

  task automatic check(input logic [P-1:0] rel, input logic rdy,
                       input logic [P-1:0] eRel, input logic eRdy, input string tag);
    checks++;
    if (rel !== eRel || rdy !== eRdy) begin
      fails++;
      $display("FAIL %s: releaseVec=%h insReady=%b expected releaseVec=%h insReady=%b",
               tag, rel, rdy, eRel, eRdy);
    end
  endtask

  // Driver: apply one cycle of stimulus, queue the outcome after the next edge.
  task automatic step(input logic [P-1:0] w, input logic iv, input logic [P-1:0] im,
                      input logic [P-1:0] eRel, input logic eRdy, input string tag);
    expT e;
    waitVec  = w;
    insValid = iv;
    insMask  = im;
    e.rel = eRel;
    e.rdy = eRdy;
    e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: compare after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expT e;
        e = expQ.pop_front();
        check(releaseVec, insReady, e.rel, e.rdy, e.tag);
      end
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(releaseVec, insReady, '0, 1'b1, "R1 during reset");
    rstN = 1'b1;
    @(negedge clk);
    check(releaseVec, insReady, '0, 1'b1, "R1 after reset");

    // Basic completion.
    step(8'h00, 1, 8'h03, 8'h00, 1, "R4 insert");
    step(8'h01, 0, 8'h00, 8'h00, 1, "R5 partial wait");
    step(8'h03, 0, 8'h00, 8'h03, 1, "R4 release");
    step(8'h00, 0, 8'h00, 8'h00, 1, "R4 single pulse");

    // Younger independent barrier overtakes older one.
    step(8'h00, 1, 8'h0C, 8'h00, 1, "R6 insert old");
    step(8'h00, 1, 8'h30, 8'h00, 1, "R6 insert young");
    step(8'h30, 0, 8'h00, 8'h30, 1, "R6 young first");
    step(8'h0C, 0, 8'h00, 8'h0C, 1, "R6 old later");
    step(8'h00, 0, 8'h00, 8'h00, 1, "R6 idle");

    // Overlapping barriers keep their order.
    step(8'h00, 1, 8'h03, 8'h00, 1, "R7 insert old");
    step(8'h00, 1, 8'h06, 8'h00, 1, "R7 insert young");
    step(8'h06, 0, 8'h00, 8'h00, 1, "R7 young blocked");
    step(8'h07, 0, 8'h00, 8'h03, 1, "R7 old fires alone");
    step(8'h07, 0, 8'h00, 8'h00, 1, "R9 released proc not waiting");
    step(8'h07, 0, 8'h00, 8'h06, 1, "R7 young after old");
    step(8'h00, 0, 8'h00, 8'h00, 1, "R7 idle");

    // Disjoint barriers in one cycle.
    step(8'h00, 1, 8'h11, 8'h00, 1, "R8 insert a");
    step(8'h00, 1, 8'h22, 8'h00, 1, "R8 insert b");
    step(8'h00, 1, 8'h44, 8'h00, 1, "R8 insert c");
    step(8'h73, 0, 8'h00, 8'h33, 1, "R8 union, R10 proc6 held");
    step(8'h44, 0, 8'h00, 8'h44, 1, "R8 third");
    step(8'h00, 0, 8'h00, 8'h00, 1, "R8 idle");

    // Zero mask, full buffer, refused insert.
    step(8'h00, 1, 8'h00, 8'h00, 1, "R3 zero mask");
    step(8'h00, 1, 8'h01, 8'h00, 1, "R3 fill 1");
    step(8'h00, 1, 8'h02, 8'h00, 1, "R3 fill 2");
    step(8'h00, 1, 8'h04, 8'h00, 1, "R3 fill 3 ready");
    step(8'h00, 1, 8'h08, 8'h00, 0, "R2 full");
    step(8'h00, 1, 8'h80, 8'h00, 0, "R2 refused insert");
    step(8'h80, 0, 8'h00, 8'h00, 0, "R2 refused not stored");
    step(8'h81, 0, 8'h00, 8'h01, 1, "R4 slot freed");
    step(8'h80, 0, 8'h00, 8'h00, 1, "R2 refused never fires");

    // Insert an overlapping mask while the older one completes.
    step(8'h0E, 1, 8'h02, 8'h0E, 1, "R7 insert during fire");
    step(8'h02, 0, 8'h00, 8'h00, 1, "R9 just released");
    step(8'h02, 0, 8'h00, 8'h02, 1, "R7 new entry not blocked");
    step(8'h00, 0, 8'h00, 8'h00, 1, "R7 idle");

    wait (expQ.size() == 0);
    @(negedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule